// File: doc/BRIEF.md
# Processor Interrupt Acceptance Unit

This unit sits beside a processor core and decides when the core takes an interrupt and what state the entry leaves behind. It watches a reset request, one non-maskable interrupt (NMI) line and six maskable request lines. It keeps the three control flags of the program status word (PSW): NMI-in-progress, exception-in-progress and interrupt-disable. It also keeps a 32-bit cause register and two saved PC/PSW pairs, one for the NMI level and one for the maskable level.

The core raises `take_i` at each instruction boundary where an interrupt may be taken, and raises `ret_i` when it executes a return from an interrupt. When the unit takes an event, it emits a one-cycle `redir_o` pulse together with `redir_addr_o`. The core must fetch from that address next. An NMI request that is blocked is held as a single pending event. A blocked maskable request stays pending until it is taken.

Top module: `irq_accept_unit`

## Requirements
- R1: `rst_ni` low sets the PSW to 0x20, clears the cause register, clears both save pairs and drops every pending request. A `reset_req_i` at a clock edge gives, after that edge, a `redir_o` pulse with address 0, a PSW of 0x20 and a cause register of 0, and drops all pending requests.
- R2: PSW flag positions are: bit 7 NMI-in-progress (NP), bit 6 exception-in-progress (EP), bit 5 interrupt-disable (ID). When an NMI is taken, `pc_i` and the PSW go into the NMI save pair, NP and ID are set, EP is cleared, and a redirect to 0x10 is issued.
- R3: An NMI entry writes 0x0010 into cause bits 31:16 and leaves cause bits 15:0 unchanged.
- R4: While NP is set, an NMI is not taken. It stays pending as one event and is retried at every `take_i`. Further NMI edges that arrive while one is pending add nothing.
- R5: While NP or ID is set, a maskable request is not taken. It stays pending until a later `take_i` finds both flags clear.
- R6: When a maskable request is taken, `pc_i` and the PSW go into the maskable save pair, ID is set, EP is cleared, cause bits 15:0 receive the vector, and cause bits 31:16 are unchanged.
- R7: Maskable line i (0 to 5) vectors to 0x80 + 0x10*i. When several lines are pending, the lowest index is taken first.
- R8: Each request is latched on its rising edge, so a request whose edge is sampled at one clock edge can be taken at the next. A maskable latch is cleared only when its own line is taken.
- R9: On `ret_i`, the PC and PSW come from the NMI save pair if NP is set, and from the maskable save pair otherwise. A redirect to the restored PC is issued.
- R10: `redir_o` lasts one cycle per event, and at most one event is handled per cycle. The priority order is reset request, then return, then NMI, then maskable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reset_req_i | input | 1 | Synchronous reset event request |
| nmi_i | input | 1 | Non-maskable request line |
| irq_i | input | 6 | Maskable request lines, index 0 has top priority |
| take_i | input | 1 | Core is at a point where an interrupt may be taken |
| ret_i | input | 1 | Core executes a return from interrupt |
| pc_i | input | 32 | PC to save on entry |
| redir_o | output | 1 | One-cycle redirect pulse |
| redir_addr_o | output | 32 | Address the core fetches next |
| psw_o | output | 8 | Program status word |
| cause_o | output | 32 | Cause register: NMI half 31:16, maskable half 15:0 |
| nmi_save_pc_o | output | 32 | Saved PC, NMI level |
| nmi_save_psw_o | output | 8 | Saved PSW, NMI level |
| int_save_pc_o | output | 32 | Saved PC, maskable level |
| int_save_psw_o | output | 8 | Saved PSW, maskable level |

## Verification
A wrong pending latch shows up at the first `take_i` after the flags clear. It appears as a missing redirect, an extra redirect, or a redirect to the wrong vector, one cycle after the edge that should have taken the event. A wrong PSW flag shows up on `psw_o` right after the entry. It also shows up at the next return, which picks the wrong save pair and redirects to the wrong PC. The cause halves are checked after every entry, so a write to the wrong half is visible within a single cycle.

// File: rtl/irq_accept_pkg.sv
package irq_accept_pkg;
   localparam int PSW_NP_BIT = 7;
   localparam int PSW_EP_BIT = 6;
   localparam int PSW_ID_BIT = 5;

   typedef enum logic [2:0] {
      EV_NONE,
      EV_RESET,
      EV_RETURN,
      EV_NMI,
      EV_MASK
   } irq_event_e;
endpackage

// File: rtl/irq_edge_latch.sv
module irq_edge_latch #(
   parameter int N = 1
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic [N-1:0] line_i,
   input  logic [N-1:0] clr_i,
   input  logic         drop_i,
   output logic [N-1:0] pend_o
);
   for (genvar g = 0; g < N; g++) begin : g_line
      logic prev_q;
      logic pend_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            prev_q <= 1'b0;
            pend_q <= 1'b0;
         end else begin
            prev_q <= line_i[g];
            if (drop_i)
               pend_q <= 1'b0;
            else if (line_i[g] && !prev_q)
               pend_q <= 1'b1;
            else if (clr_i[g])
               pend_q <= 1'b0;
         end
      end
      assign pend_o[g] = pend_q;
   end
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
   parameter int N         = 6,
   parameter bit LOW_FIRST = 1'b1,
   localparam int IW       = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]  req_i,
   output logic [N-1:0]  grant_o,
   output logic [IW-1:0] idx_o
);
   if (LOW_FIRST) begin : g_low
      always_comb begin
         logic found;
         found   = 1'b0;
         grant_o = '0;
         idx_o   = '0;
         for (int i = 0; i < N; i++) begin
            if (req_i[i] && !found) begin
               found      = 1'b1;
               grant_o[i] = 1'b1;
               idx_o      = IW'(i);
            end
         end
      end
   end else begin : g_high
      always_comb begin
         logic found;
         found   = 1'b0;
         grant_o = '0;
         idx_o   = '0;
         for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i] && !found) begin
               found      = 1'b1;
               grant_o[i] = 1'b1;
               idx_o      = IW'(i);
            end
         end
      end
   end
endmodule

// File: rtl/irq_save_pair.sv
module irq_save_pair #(
   parameter int AW = 32,
   parameter int PW = 8
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          cap_i,
   input  logic [AW-1:0] pc_i,
   input  logic [PW-1:0] psw_i,
   output logic [AW-1:0] pc_o,
   output logic [PW-1:0] psw_o
);
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         pc_o  <= '0;
         psw_o <= '0;
      end else if (cap_i) begin
         pc_o  <= pc_i;
         psw_o <= psw_i;
      end
   end
endmodule

// File: rtl/irq_accept_unit.sv
module irq_accept_unit
   import irq_accept_pkg::*;
#(
   parameter int          ADDR_W    = 32,
   parameter int          PSW_W     = 8,
   parameter int          CAUSE_W   = 32,
   parameter int          NUM_IRQ   = 6,
   parameter int unsigned VEC_BASE  = 32'h80,
   parameter int unsigned VEC_STEP  = 32'h10,
   parameter int unsigned NMI_VEC   = 32'h10,
   parameter int unsigned NMI_CODE  = 32'h10,
   parameter int unsigned RESET_PSW = 32'h20,
   parameter bit          LOW_FIRST = 1'b1,
   localparam int HALF              = CAUSE_W / 2,
   localparam int IW                = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               reset_req_i,
   input  logic               nmi_i,
   input  logic [NUM_IRQ-1:0] irq_i,
   input  logic               take_i,
   input  logic               ret_i,
   input  logic [ADDR_W-1:0]  pc_i,
   output logic               redir_o,
   output logic [ADDR_W-1:0]  redir_addr_o,
   output logic [PSW_W-1:0]   psw_o,
   output logic [CAUSE_W-1:0] cause_o,
   output logic [ADDR_W-1:0]  nmi_save_pc_o,
   output logic [PSW_W-1:0]   nmi_save_psw_o,
   output logic [ADDR_W-1:0]  int_save_pc_o,
   output logic [PSW_W-1:0]   int_save_psw_o
);
   if (NUM_IRQ < 1 || PSW_W < 8 || (CAUSE_W % 2) != 0 || HALF < 8) begin : g_bad_cfg
      $error("irq_accept_unit: unsupported parameter set");
   end

   irq_event_e         ev;
   logic               nmi_pend;
   logic [NUM_IRQ-1:0] irq_pend;
   logic [NUM_IRQ-1:0] pick_grant;
   logic [NUM_IRQ-1:0] int_grant;
   logic [IW-1:0]      pick_idx;
   logic               nmi_go, int_go, drop_all;
   logic [ADDR_W-1:0]  vec_addr;
   logic [PSW_W-1:0]   psw_q, psw_d;
   logic [CAUSE_W-1:0] cause_q, cause_d;
   logic [ADDR_W-1:0]  addr_d;
   logic               np, idis;

   assign np   = psw_q[PSW_NP_BIT];
   assign idis = psw_q[PSW_ID_BIT];

   irq_edge_latch #(.N(1)) u_nmi_latch (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .line_i(nmi_i),
      .clr_i (nmi_go),
      .drop_i(drop_all),
      .pend_o(nmi_pend)
   );

   irq_edge_latch #(.N(NUM_IRQ)) u_irq_latch (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .line_i(irq_i),
      .clr_i (int_grant),
      .drop_i(drop_all),
      .pend_o(irq_pend)
   );

   irq_prio_pick #(.N(NUM_IRQ), .LOW_FIRST(LOW_FIRST)) u_pick (
      .req_i  (irq_pend),
      .grant_o(pick_grant),
      .idx_o  (pick_idx)
   );

   always_comb begin
      if (reset_req_i)
         ev = EV_RESET;
      else if (ret_i)
         ev = EV_RETURN;
      else if (take_i && nmi_pend && !np)
         ev = EV_NMI;
      else if (take_i && (|irq_pend) && !np && !idis)
         ev = EV_MASK;
      else
         ev = EV_NONE;
   end

   assign drop_all  = (ev == EV_RESET);
   assign nmi_go    = (ev == EV_NMI);
   assign int_go    = (ev == EV_MASK);
   assign int_grant = int_go ? pick_grant : '0;
   assign vec_addr  = ADDR_W'(VEC_BASE) + ADDR_W'(pick_idx) * ADDR_W'(VEC_STEP);

   irq_save_pair #(.AW(ADDR_W), .PW(PSW_W)) u_nmi_pair (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .cap_i (nmi_go),
      .pc_i  (pc_i),
      .psw_i (psw_q),
      .pc_o  (nmi_save_pc_o),
      .psw_o (nmi_save_psw_o)
   );

   irq_save_pair #(.AW(ADDR_W), .PW(PSW_W)) u_int_pair (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .cap_i (int_go),
      .pc_i  (pc_i),
      .psw_i (psw_q),
      .pc_o  (int_save_pc_o),
      .psw_o (int_save_psw_o)
   );

   always_comb begin
      psw_d   = psw_q;
      cause_d = cause_q;
      addr_d  = '0;
      unique case (ev)
         EV_RESET: begin
            psw_d   = PSW_W'(RESET_PSW);
            cause_d = '0;
         end
         EV_RETURN: begin
            psw_d  = np ? nmi_save_psw_o : int_save_psw_o;
            addr_d = np ? nmi_save_pc_o : int_save_pc_o;
         end
         EV_NMI: begin
            psw_d[PSW_NP_BIT]          = 1'b1;
            psw_d[PSW_EP_BIT]          = 1'b0;
            psw_d[PSW_ID_BIT]          = 1'b1;
            cause_d[CAUSE_W-1:HALF]    = HALF'(NMI_CODE);
            addr_d                     = ADDR_W'(NMI_VEC);
         end
         EV_MASK: begin
            psw_d[PSW_EP_BIT]          = 1'b0;
            psw_d[PSW_ID_BIT]          = 1'b1;
            cause_d[HALF-1:0]          = HALF'(vec_addr);
            addr_d                     = vec_addr;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         psw_q        <= PSW_W'(RESET_PSW);
         cause_q      <= '0;
         redir_o      <= 1'b0;
         redir_addr_o <= '0;
      end else begin
         psw_q        <= psw_d;
         cause_q      <= cause_d;
         redir_o      <= (ev != EV_NONE);
         redir_addr_o <= addr_d;
      end
   end

   assign psw_o   = psw_q;
   assign cause_o = cause_q;
endmodule

// File: rtl/irq_accept_chk.sv
module irq_accept_chk
   import irq_accept_pkg::*;
#(
   parameter int          ADDR_W    = 32,
   parameter int          PSW_W     = 8,
   parameter int          CAUSE_W   = 32,
   parameter int          NUM_IRQ   = 6,
   parameter int unsigned NMI_VEC   = 32'h10,
   parameter int unsigned NMI_CODE  = 32'h10,
   parameter int unsigned RESET_PSW = 32'h20,
   localparam int HALF              = CAUSE_W / 2
) (
   input logic               clk_i,
   input logic               rst_ni,
   input logic               reset_req_i,
   input logic               redir_o,
   input logic [ADDR_W-1:0]  redir_addr_o,
   input logic [PSW_W-1:0]   psw_o,
   input logic [CAUSE_W-1:0] cause_o,
   input logic               nmi_go,
   input logic               int_go,
   input logic [NUM_IRQ-1:0] int_grant
);
   AST_ONE_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(nmi_go && int_go) && $onehot0(int_grant) && (int_go == (|int_grant))); // R10

   AST_RESET_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
      reset_req_i |=> redir_o && redir_addr_o == '0 && psw_o == PSW_W'(RESET_PSW) && cause_o == '0); // R1

   AST_NMI_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      nmi_go |=> redir_o && redir_addr_o == ADDR_W'(NMI_VEC) && psw_o[PSW_NP_BIT]
                 && psw_o[PSW_ID_BIT] && !psw_o[PSW_EP_BIT]); // R2

   AST_NMI_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      nmi_go |=> cause_o[HALF-1:0] == $past(cause_o[HALF-1:0])
                 && cause_o[CAUSE_W-1:HALF] == HALF'(NMI_CODE)); // R3

   AST_NMI_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      psw_o[PSW_NP_BIT] |-> !nmi_go); // R4

   AST_MASK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (psw_o[PSW_NP_BIT] || psw_o[PSW_ID_BIT]) |-> !int_go); // R5

   AST_MASK_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      int_go |=> redir_o && psw_o[PSW_ID_BIT] && !psw_o[PSW_EP_BIT]
                 && cause_o[HALF-1:0] == redir_addr_o[HALF-1:0]
                 && cause_o[CAUSE_W-1:HALF] == $past(cause_o[CAUSE_W-1:HALF])); // R6
endmodule

bind irq_accept_unit irq_accept_chk #(
   .ADDR_W   (ADDR_W),
   .PSW_W    (PSW_W),
   .CAUSE_W  (CAUSE_W),
   .NUM_IRQ  (NUM_IRQ),
   .NMI_VEC  (NMI_VEC),
   .NMI_CODE (NMI_CODE),
   .RESET_PSW(RESET_PSW)
) chk_i (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .reset_req_i (reset_req_i),
   .redir_o     (redir_o),
   .redir_addr_o(redir_addr_o),
   .psw_o       (psw_o),
   .cause_o     (cause_o),
   .nmi_go      (nmi_go),
   .int_go      (int_go),
   .int_grant   (int_grant)
);

// File: tb/irq_accept_unit_tb_top.sv
`timescale 1ns/1ps
module irq_accept_unit_tb_top;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        reset_req, nmi, take, reti;
   logic [5:0]  irq;
   logic [31:0] pc;
   logic        redir;
   logic [31:0] redir_addr, cause, nmi_pc, int_pc;
   logic [7:0]  psw, nmi_psw, int_psw;
   int          errors = 0;
   int          checks = 0;
   bit          done = 1'b0;

   always #4 clk = ~clk;

   irq_accept_unit dut_i (
      .clk_i         (clk),
      .rst_ni        (rst_n),
      .reset_req_i   (reset_req),
      .nmi_i         (nmi),
      .irq_i         (irq),
      .take_i        (take),
      .ret_i         (reti),
      .pc_i          (pc),
      .redir_o       (redir),
      .redir_addr_o  (redir_addr),
      .psw_o         (psw),
      .cause_o       (cause),
      .nmi_save_pc_o (nmi_pc),
      .nmi_save_psw_o(nmi_psw),
      .int_save_pc_o (int_pc),
      .int_save_psw_o(int_psw)
   );

   // {line mask[5:0], expected vector[7:0]}
   localparam logic [13:0] VEC_TBL [9] = '{
      {6'b000001, 8'h80}, {6'b000010, 8'h90}, {6'b000100, 8'hA0},
      {6'b001000, 8'hB0}, {6'b010000, 8'hC0}, {6'b100000, 8'hD0},
      {6'b101100, 8'hA0}, {6'b110000, 8'hC0}, {6'b111111, 8'h80}
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic hw_reset();
      rst_n = 1'b0; reset_req = 0; nmi = 0; take = 0; reti = 0; irq = '0; pc = '0;
      step(); step();
      rst_n = 1'b1;
      step();
   endtask

   task automatic do_ret(input logic [31:0] exp_addr, input logic [7:0] exp_psw, input string tag);
      take = 0; reti = 1;
      step();
      reti = 0;
      chk({tag, " ret redir"}, 32'(redir), 1);
      chk({tag, " ret addr"}, redir_addr, exp_addr);
      chk({tag, " ret psw"}, 32'(psw), 32'(exp_psw));
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: actual=expired expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      // table walk: vector and priority per line pattern (R7, R6, R8)
      for (int r = 0; r < 9; r++) begin
         hw_reset();
         do_ret(32'h0, 8'h00, "R9 tbl");
         irq = VEC_TBL[r][13:8];
         step();
         irq = '0; take = 1;
         step();
         chk("R7 tbl redir", 32'(redir), 1);
         chk("R7 tbl addr", redir_addr, 32'(VEC_TBL[r][7:0]));
         chk("R6 tbl cause", cause, 32'(VEC_TBL[r][7:0]));
         chk("R6 tbl psw", 32'(psw), 32'h20);
         take = 0;
      end

      // reset state
      hw_reset();
      chk("R1 psw", 32'(psw), 32'h20);
      chk("R1 cause", cause, 0);
      chk("R1 redir", 32'(redir), 0);

      // maskable blocked by ID after reset
      irq = 6'b000001; take = 1; pc = 32'h100;
      step();
      irq = '0;
      step(); step();
      chk("R5 blocked", 32'(redir), 0);
      do_ret(32'h0, 8'h00, "R9 int");
      take = 1; pc = 32'h200;
      step();
      chk("R5 later redir", 32'(redir), 1);
      chk("R7 addr", redir_addr, 32'h80);
      chk("R6 psw", 32'(psw), 32'h20);
      chk("R6 cause", cause, 32'h80);
      chk("R6 save pc", int_pc, 32'h200);
      chk("R6 save psw", 32'(int_psw), 0);
      step();
      chk("R10 pulse", 32'(redir), 0);

      // NMI inside maskable handler
      nmi = 1; pc = 32'h300;
      step();
      chk("R8 not yet", 32'(redir), 0);
      nmi = 0;
      step();
      chk("R2 redir", 32'(redir), 1);
      chk("R2 addr", redir_addr, 32'h10);
      chk("R2 psw", 32'(psw), 32'hA0);
      chk("R2 save pc", nmi_pc, 32'h300);
      chk("R2 save psw", 32'(nmi_psw), 32'h20);
      chk("R3 cause", cause, 32'h0010_0080);

      // two more NMIs while NP set
      nmi = 1; step(); nmi = 0; step();
      nmi = 1; step(); nmi = 0; step();
      chk("R4 blocked", 32'(redir), 0);
      do_ret(32'h300, 8'h20, "R9 nmi");
      take = 1; pc = 32'h400;
      step();
      chk("R4 retried", 32'(redir), 1);
      chk("R4 addr", redir_addr, 32'h10);
      chk("R4 save pc", nmi_pc, 32'h400);
      do_ret(32'h400, 8'h20, "R9 nmi2");
      take = 1;
      step(); step();
      chk("R4 single", 32'(redir), 0);
      do_ret(32'h200, 8'h00, "R9 int2");

      // simultaneous NMI and maskable
      nmi = 1; irq = 6'b001010; take = 1; pc = 32'h500;
      step();
      nmi = 0; irq = '0;
      step();
      chk("R10 nmi first", redir_addr, 32'h10);
      chk("R10 psw", 32'(psw), 32'hA0);
      chk("R3 keep low", cause, 32'h0010_0080);
      do_ret(32'h500, 8'h00, "R9 nmi3");
      take = 1; pc = 32'h600;
      step();
      chk("R7 second", redir_addr, 32'h90);
      chk("R6 cause hi kept", cause, 32'h0010_0090);
      do_ret(32'h600, 8'h00, "R9 int3");
      take = 1; pc = 32'h700;
      step();
      chk("R8 latch held", redir_addr, 32'hB0);
      chk("R6 cause", cause, 32'h0010_00B0);

      // reset request drops pending
      take = 0; irq = 6'b100000;
      step();
      irq = '0;
      step();
      reset_req = 1;
      step();
      reset_req = 0;
      chk("R1 req redir", 32'(redir), 1);
      chk("R1 req addr", redir_addr, 0);
      chk("R1 req psw", 32'(psw), 32'h20);
      chk("R1 req cause", cause, 0);
      do_ret(32'h700, 8'h00, "R9 int4");
      take = 1;
      step(); step();
      chk("R1 dropped", 32'(redir), 0);
      take = 0;

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule